// File: doc/BRIEF.md
# Three-Port Parallel I/O Controller

The block sits on a CPU bus. It gives the CPU three 8-bit general-purpose ports, called A, B and C. Port C is handled as two 4-bit halves, and each half has its own direction. The CPU uses a two-bit register address, an active-low chip select and active-low read and write strobes. With these it loads a control word, writes output values into per-port latches, and reads the ports back. Only plain input/output operation is provided.

A control word with its top bit set is a configuration word. It sets the direction of the four port groups and clears every output latch. A control word with its top bit clear changes one port C bit and leaves the other bits alone. The pins are split into separate input, output-value and output-enable vectors. A pin is driven only when its group is an output.

A small bus state machine has three states: `BUS_IDLE`, `BUS_WRITE_HOLD` and `BUS_READ`. Its transitions are:

- `BUS_IDLE` goes to `BUS_WRITE_HOLD` when a write is requested. This transition commits the write.
- `BUS_IDLE` goes to `BUS_READ` when a read is requested.
- `BUS_WRITE_HOLD` returns to `BUS_IDLE`, or moves to `BUS_READ`, once the write strobe or chip select is released.
- `BUS_READ` goes to `BUS_WRITE_HOLD` when a write arrives. This transition also commits the write.
- `BUS_READ` returns to `BUS_IDLE` when the read ends.

Because of this state machine, a held write strobe commits exactly once.

Top module: `ppi_port3`

## Requirements
- R1: After reset, every output enable is 0 and every output latch is 0. A read of the control register (address 3) returns 0xFF.
- R2: The address selects a register as follows: 0 is port A, 1 is port B, 2 is port C and 3 is control. A write reaches only the register it addresses.
- R3: A control word with bit 7 = 1 and bits 6, 5 and 2 all 0 sets the group directions. Bit 4 sets port A, bit 3 sets C[7:4], bit 1 sets port B and bit 0 sets C[3:0]. A value of 1 means input. Every output enable in a group equals the inverse of that group's direction bit.
- R4: A valid configuration word clears the A, B and C output latches to 0.
- R5: A control word with bit 7 = 1 and any of bits 6, 5 or 2 set is ignored. Directions and latches stay unchanged.
- R6: A value written to an output port appears on its output pins. It stays there after the strobe ends.
- R7: Reading a port whose group is an input returns the live pin values. Reading a port whose group is an output returns its latch.
- R8: The two halves of port C each follow their own direction, both for output enables and for read-back.
- R9: A control word with bit 7 = 0 writes bit 0 into the port C latch bit whose index is given by bits 3:1. All other latch bits are unchanged.
- R10: A write is committed on the first clock edge where chip select and the write strobe are both low. Further edges while both stay low commit nothing. A write strobe with chip select high has no effect.
- R11: The read data output and its enable are active only while chip select and the read strobe are both low. Otherwise the data output is 0.
- R12: Writing to a port configured as input leaves its output enables at 0. Reads of that port keep returning the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register select |
| bus_din | input | 8 | Write data from the CPU |
| bus_dout | output | 8 | Read data to the CPU |
| bus_oe | output | 1 | Read data valid / bus drive enable |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C output enables |

## Verification
The assertions assume that the CPU never asserts the read and write strobes together. They also assume that bus data and address are stable on the edge that commits a write. Under these assumptions, at most one bit of port C can change after a single-bit command, and an ignored configuration word leaves the state untouched. The bench changes inputs only on falling clock edges and never overlaps a read with a write. It holds the write strobe for at least one rising edge and releases it for at least one rising edge before the next access. The one exception is the deliberate held-strobe test, which keeps the strobe low across several edges while the data changes.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

    localparam int unsigned PORT_W = 8;

    typedef enum logic [1:0] {
        BUS_IDLE       = 2'd0,
        BUS_WRITE_HOLD = 2'd1,
        BUS_READ       = 2'd2
    } bus_state_e;

    localparam logic [1:0] SEL_A   = 2'd0;
    localparam logic [1:0] SEL_B   = 2'd1;
    localparam logic [1:0] SEL_C   = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

    // Control word bit positions
    localparam int unsigned CW_KIND   = 7;
    localparam int unsigned CW_MODE_H = 6;
    localparam int unsigned CW_MODE_L = 5;
    localparam int unsigned CW_DIR_A  = 4;
    localparam int unsigned CW_DIR_CU = 3;
    localparam int unsigned CW_MODE_B = 2;
    localparam int unsigned CW_DIR_B  = 1;
    localparam int unsigned CW_DIR_CL = 0;

    typedef struct packed {
        logic a_in;
        logic cu_in;
        logic b_in;
        logic cl_in;
    } dir_cfg_t;

endpackage

// File: rtl/ppi_bus_fsm.sv
module ppi_bus_fsm
    import ppi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_stb,
    output logic rd_act
);

    bus_state_e state, state_nxt;
    logic       wr_req, rd_req;

    assign wr_req = !cs_n && !wr_n;
    assign rd_req = !cs_n && !rd_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            BUS_IDLE: begin
                if (wr_req)      state_nxt = BUS_WRITE_HOLD;
                else if (rd_req) state_nxt = BUS_READ;
            end
            BUS_WRITE_HOLD: begin
                if (!wr_req) state_nxt = rd_req ? BUS_READ : BUS_IDLE;
            end
            BUS_READ: begin
                if (wr_req)      state_nxt = BUS_WRITE_HOLD;
                else if (!rd_req) state_nxt = BUS_IDLE;
            end
            default: state_nxt = BUS_IDLE;
        endcase
    end

    // Output process: commit only on entry into the hold state
    always_comb begin
        wr_stb = wr_req && (state != BUS_WRITE_HOLD);
        rd_act = rd_req && !wr_req;
    end

    // R10: a held strobe commits once
    a_r10_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R10: the hold state persists while the strobe stays low
    a_r10_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BUS_WRITE_HOLD && wr_req) |=> (state == BUS_WRITE_HOLD));

endmodule

// File: rtl/ppi_ctl_regs.sv
module ppi_ctl_regs
    import ppi_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output dir_cfg_t     dir,
    output logic [W-1:0] lat_a,
    output logic [W-1:0] lat_b,
    output logic [W-1:0] lat_c
);

    localparam int unsigned IDX_W = $clog2(W);

    logic             to_ctl, mode_zero, def_ok, is_bsr;
    logic [IDX_W-1:0] bit_idx;

    assign to_ctl    = (addr == SEL_CTL);
    assign mode_zero = !wdata[CW_MODE_H] && !wdata[CW_MODE_L] && !wdata[CW_MODE_B];
    assign def_ok    = to_ctl && wdata[CW_KIND] && mode_zero;
    assign is_bsr    = to_ctl && !wdata[CW_KIND];
    assign bit_idx   = wdata[IDX_W:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir   <= '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};
            lat_a <= '0;
            lat_b <= '0;
            lat_c <= '0;
        end else if (wr_stb) begin
            unique case (addr)
                SEL_A: lat_a <= wdata;
                SEL_B: lat_b <= wdata;
                SEL_C: lat_c <= wdata;
                SEL_CTL: begin
                    if (def_ok) begin
                        dir.a_in  <= wdata[CW_DIR_A];
                        dir.cu_in <= wdata[CW_DIR_CU];
                        dir.b_in  <= wdata[CW_DIR_B];
                        dir.cl_in <= wdata[CW_DIR_CL];
                        lat_a     <= '0;
                        lat_b     <= '0;
                        lat_c     <= '0;
                    end else if (is_bsr) begin
                        lat_c[bit_idx] <= wdata[0];
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: single-bit command touches at most one bit of C, none of A or B
    a_r9_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && is_bsr) |=>
            ($countones(lat_c ^ $past(lat_c)) <= 1) && $stable(lat_a) && $stable(lat_b));

    // R4: a valid configuration empties every latch
    a_r4_def_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && def_ok) |=> (lat_a == '0 && lat_b == '0 && lat_c == '0));

    // R5: configuration with non-zero mode bits changes nothing
    a_r5_bad_mode_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && to_ctl && wdata[CW_KIND] && !mode_zero) |=>
            ($stable(dir) && $stable(lat_a) && $stable(lat_b) && $stable(lat_c)));

endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux
    import ppi_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic [1:0]   addr,
    input  dir_cfg_t     dir,
    input  logic [W-1:0] lat_a,
    input  logic [W-1:0] lat_b,
    input  logic [W-1:0] lat_c,
    input  logic [W-1:0] pin_a,
    input  logic [W-1:0] pin_b,
    input  logic [W-1:0] pin_c,
    output logic [W-1:0] rdata
);

    localparam int unsigned HALF = W / 2;

    logic [W-1:0] view_a, view_b, view_c;

    assign view_a = dir.a_in ? pin_a : lat_a;
    assign view_b = dir.b_in ? pin_b : lat_b;

    for (genvar i = 0; i < W; i++) begin : g_c_view
        if (i >= HALF) begin : g_upper
            assign view_c[i] = dir.cu_in ? pin_c[i] : lat_c[i];
        end else begin : g_lower
            assign view_c[i] = dir.cl_in ? pin_c[i] : lat_c[i];
        end
    end

    always_comb begin
        unique case (addr)
            SEL_A:   rdata = view_a;
            SEL_B:   rdata = view_b;
            SEL_C:   rdata = view_c;
            default: rdata = '1;
        endcase
    end

endmodule

// File: rtl/ppi_port3.sv
module ppi_port3
    import ppi_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic [1:0]   addr,
    input  logic [W-1:0] bus_din,
    output logic [W-1:0] bus_dout,
    output logic         bus_oe,
    input  logic [W-1:0] pa_in,
    output logic [W-1:0] pa_out,
    output logic [W-1:0] pa_oe,
    input  logic [W-1:0] pb_in,
    output logic [W-1:0] pb_out,
    output logic [W-1:0] pb_oe,
    input  logic [W-1:0] pc_in,
    output logic [W-1:0] pc_out,
    output logic [W-1:0] pc_oe
);

    localparam int unsigned HALF = W / 2;

    logic         wr_stb, rd_act;
    dir_cfg_t     dir;
    logic [W-1:0] lat_a, lat_b, lat_c, rdata;

    ppi_bus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .wr_stb (wr_stb),
        .rd_act (rd_act)
    );

    ppi_ctl_regs #(.W(W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .addr   (addr),
        .wdata  (bus_din),
        .dir    (dir),
        .lat_a  (lat_a),
        .lat_b  (lat_b),
        .lat_c  (lat_c)
    );

    ppi_read_mux #(.W(W)) u_rmux (
        .addr  (addr),
        .dir   (dir),
        .lat_a (lat_a),
        .lat_b (lat_b),
        .lat_c (lat_c),
        .pin_a (pa_in),
        .pin_b (pb_in),
        .pin_c (pc_in),
        .rdata (rdata)
    );

    assign pa_out = lat_a;
    assign pb_out = lat_b;
    assign pc_out = lat_c;
    assign pa_oe  = {W{~dir.a_in}};
    assign pb_oe  = {W{~dir.b_in}};

    for (genvar i = 0; i < W; i++) begin : g_pc_oe
        if (i >= HALF) begin : g_upper
            assign pc_oe[i] = ~dir.cu_in;
        end else begin : g_lower
            assign pc_oe[i] = ~dir.cl_in;
        end
    end

    assign bus_oe   = rd_act;
    assign bus_dout = rd_act ? rdata : '0;

    // R1: control register reads back as all ones
    a_r1_ctl_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && addr == SEL_CTL) |-> (bus_dout == '1));

    // R3, R8: enables move together per group
    a_r3_oe_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        ((pa_oe == '0) || (pa_oe == '1)) && ((pb_oe == '0) || (pb_oe == '1)) &&
        ((pc_oe[W-1:HALF] == '0) || (pc_oe[W-1:HALF] == '1)) &&
        ((pc_oe[HALF-1:0] == '0) || (pc_oe[HALF-1:0] == '1)));

endmodule

// File: tb/ppi_port3_bench.sv
module ppi_port3_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n, rd_n, wr_n;
    logic [1:0] addr;
    logic [7:0] bus_din, bus_dout;
    logic       bus_oe;
    logic [7:0] pa_in, pa_out, pa_oe;
    logic [7:0] pb_in, pb_out, pb_oe;
    logic [7:0] pc_in, pc_out, pc_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ppi_port3 u_ppi_port3 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // Vector: {kind, addr, data, req}; kind 0 write, 1 read, 2 enables, 3 output values
    localparam int NV = 37;
    localparam logic [15:0] VEC [0:NV-1] = '{
        {2'd1, 2'd3, 8'hFF, 4'd1},   // R1 control reads ones
        {2'd1, 2'd0, 8'h3C, 4'd7},   // R7 input read is live
        {2'd2, 2'd0, 8'h00, 4'd1},   // R1
        {2'd2, 2'd2, 8'h00, 4'd1},   // R1
        {2'd0, 2'd3, 8'h80, 4'd3},   // R3 all outputs
        {2'd2, 2'd0, 8'hFF, 4'd3},
        {2'd2, 2'd1, 8'hFF, 4'd3},
        {2'd2, 2'd2, 8'hFF, 4'd3},
        {2'd0, 2'd0, 8'h5A, 4'd6},   // R6
        {2'd3, 2'd0, 8'h5A, 4'd6},
        {2'd1, 2'd0, 8'h5A, 4'd7},   // R7 output reads latch
        {2'd0, 2'd3, 8'h8A, 4'd8},   // R8 B, C-upper in; A, C-lower out
        {2'd2, 2'd0, 8'hFF, 4'd8},
        {2'd2, 2'd1, 8'h00, 4'd8},
        {2'd2, 2'd2, 8'h0F, 4'd8},
        {2'd3, 2'd0, 8'h00, 4'd4},   // R4 latch cleared
        {2'd0, 2'd2, 8'hFF, 4'd8},
        {2'd3, 2'd2, 8'hFF, 4'd8},
        {2'd1, 2'd2, 8'h9F, 4'd8},   // R8 mixed read-back
        {2'd0, 2'd1, 8'h77, 4'd12},  // R12
        {2'd2, 2'd1, 8'h00, 4'd12},
        {2'd1, 2'd1, 8'hA5, 4'd12},
        {2'd0, 2'd3, 8'h00, 4'd9},   // R9 clear bit 0
        {2'd3, 2'd2, 8'hFE, 4'd9},
        {2'd0, 2'd3, 8'h0C, 4'd9},   // R9 clear bit 6
        {2'd3, 2'd2, 8'hBE, 4'd9},
        {2'd0, 2'd3, 8'h01, 4'd9},   // R9 set bit 0
        {2'd3, 2'd2, 8'hBF, 4'd9},
        {2'd0, 2'd3, 8'hC0, 4'd5},   // R5 mode bit 6
        {2'd2, 2'd0, 8'hFF, 4'd5},
        {2'd3, 2'd2, 8'hBF, 4'd5},
        {2'd0, 2'd3, 8'h84, 4'd5},   // R5 mode bit 2
        {2'd2, 2'd2, 8'h0F, 4'd5},
        {2'd0, 2'd0, 8'h11, 4'd2},   // R2
        {2'd3, 2'd0, 8'h11, 4'd2},
        {2'd3, 2'd2, 8'hBF, 4'd2},
        {2'd1, 2'd3, 8'hFF, 4'd2}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; bus_din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = bus_dout;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    function automatic logic [7:0] pick(input logic [1:0] a, input logic [7:0] x,
                                        input logic [7:0] y, input logic [7:0] z);
        return (a == 2'd0) ? x : (a == 2'd1) ? y : z;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        addr = 2'd0; bus_din = 8'h00;
        pa_in = 8'h3C; pb_in = 8'hA5; pc_in = 8'h96;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [1:0] k, a;
            logic [7:0] d;
            string tag;
            {k, a, d} = VEC[i][15:4];
            tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
            case (k)
                2'd0: bus_write(a, d);
                2'd1: begin bus_read(a, rd); check(tag, rd, d); end
                2'd2: begin @(negedge clk); #1 check(tag, pick(a, pa_oe, pb_oe, pc_oe), d); end
                default: begin @(negedge clk); #1 check(tag, pick(a, pa_out, pb_out, pc_out), d); end
            endcase
        end

        // R10: strobe held across edges with changing data commits only the first value
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = 2'd0; bus_din = 8'h21;
        @(negedge clk); bus_din = 8'h42;
        @(negedge clk); bus_din = 8'h84;
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk); #1 check("R10 held strobe", pa_out, 8'h21);

        // R10: write strobe without chip select is ignored
        @(negedge clk);
        wr_n = 1'b0; addr = 2'd0; bus_din = 8'h99;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk); #1 check("R10 no select", pa_out, 8'h21);
        bus_write(2'd0, 8'h33);
        @(negedge clk); #1 check("R10 next write", pa_out, 8'h33);

        // R11: data bus quiet outside a selected read
        @(negedge clk); #1 check("R11 idle oe", {7'd0, bus_oe}, 8'h00);
        check("R11 idle data", bus_dout, 8'h00);
        @(negedge clk); rd_n = 1'b0; addr = 2'd3;
        #1 check("R11 unselected oe", {7'd0, bus_oe}, 8'h00);
        check("R11 unselected data", bus_dout, 8'h00);
        rd_n = 1'b1;
        bus_read(2'd0, rd); check("R11 selected read", rd, 8'h33);

        // R1: reset mid-run restores inputs and clears latches
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1 check("R1 reset pa_oe", pa_oe, 8'h00);
        check("R1 reset pb_oe", pb_oe, 8'h00);
        check("R1 reset pc_oe", pc_oe, 8'h00);
        check("R1 reset pa_out", pa_out, 8'h00);
        check("R1 reset pc_out", pc_out, 8'h00);
        bus_read(2'd3, rd); check("R1 reset ctl read", rd, 8'hFF);
        bus_read(2'd2, rd); check("R7 reset C live", rd, 8'h96);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule